// File: doc/BRIEF.md
# Dispatch Group Slot Hazard Checker

This block follows how a five-slot instruction dispatch group is filled and judges each candidate instruction offered to it. From the candidate's unit class and attribute flags, plus the current group state, it gives one of three verdicts in the same cycle. No hazard means the candidate may join the group. A stall hazard means it cannot join this group. A no-op hazard means it could join, but doing so would cause a costly pipeline recovery, so filler should be inserted first.

A scheduler offers a candidate, reads the verdict, and pulses the commit strobe when it issues that candidate. It pulses the idle strobe for a cycle in which nothing issues. Opcode decoding is not part of this block. The store-to-load address comparison is also done outside and arrives as a single overlap bit.

Unit class encoding on `cand_unit` is: 0 fixed-point, 1 load/store, 2 floating, 3 vector ALU, 4 vector permute, 5 condition-register, 6 branch, 7 pseudo. Verdict encoding on `hazard` is: 0 none, 1 stall, 2 no-op.

Top module: `dgroup_hazard_chk`

## Requirements
- R1: After synchronous reset `slots_used` is 0, `ctr_pending` is 0, and a plain fixed-point candidate gets verdict 0 (none).
- R2: A pseudo candidate (class 7) always gets verdict 0. Committing it changes neither `slots_used` nor `ctr_pending`.
- R3: A non-pseudo candidate with first-only or single set gets verdict 1 (stall) whenever `slots_used` is not 0, and verdict 0 from an empty group if nothing else applies.
- R4: A cracked candidate gets verdict 1 when `slots_used` is greater than 2. Committing a cracked instruction adds two slots.
- R5: A class 0 to 4 candidate gets verdict 1 when `slots_used` is 4. A branch (class 6) is still accepted at 4.
- R6: A condition-register candidate (class 5) gets verdict 1 once `slots_used` is 2 or more.
- R7: A non-pseudo commit adds one slot. When the total reaches five, the group closes: `slots_used` returns to 0 and `ctr_pending` clears.
- R8: Committing a branch or a single-flagged instruction closes the group at once, whatever the current count.
- R9: An idle strobe adds one slot and closes the group at five. When a non-pseudo commit occurs in the same cycle, the commit alone takes effect.
- R10: A committed CTR write sets `ctr_pending`. While it is set, a branch-through-CTR candidate gets verdict 2 (no-op). Closing the group clears it.
- R11: A load candidate with the overlap bit set gets verdict 2. The overlap bit has no effect on a candidate that is not a load.
- R12: When a stall condition and a no-op condition hold together, the verdict is 1 (stall).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_unit | input | 3 | Candidate unit class (0 FX, 1 LS, 2 FP, 3 VALU, 4 VPERM, 5 CR, 6 BR, 7 pseudo) |
| cand_first_only | input | 1 | Candidate may only open a group |
| cand_single | input | 1 | Candidate fills a whole group |
| cand_cracked | input | 1 | Candidate splits into two slots |
| cand_is_load | input | 1 | Candidate reads memory |
| cand_addr_overlap | input | 1 | Candidate load overlaps a store already in the group |
| cand_writes_ctr | input | 1 | Candidate writes the count register |
| cand_ctr_branch | input | 1 | Candidate branches through the count register |
| commit_stb | input | 1 | Candidate issues this cycle |
| idle_stb | input | 1 | Empty issue cycle |
| hazard | output | 2 | Verdict: 0 none, 1 stall, 2 no-op |
| slots_used | output | 3 | Slots filled in the open group (0 to 4) |
| ctr_pending | output | 1 | A CTR write has issued in the open group |

## Verification
A wrong slot count shows up in the verdict for the next candidate, in the same cycle after the faulty commit or idle edge. The wrong value appears as a stall for a condition-register, first-only or cracked instruction that should pass, or the reverse, and `slots_used` shows the error directly one cycle after the edge. A CTR flag that stays set after a group closes, or that is never set, shows only when a branch-through-CTR candidate is offered. The tests therefore offer one right after the write, and again right after the close.

// File: rtl/dgh_pkg.sv
package dgh_pkg;

  localparam int GROUP_SLOTS = 5;
  localparam int CNT_W       = $clog2(GROUP_SLOTS + 2);
  localparam int CR_LIMIT    = 2;
  localparam int CRACK_LIMIT = 2;
  localparam int EXEC_LIMIT  = GROUP_SLOTS - 1;

  typedef enum logic [2:0] {
    U_FX    = 3'd0,
    U_LS    = 3'd1,
    U_FP    = 3'd2,
    U_VALU  = 3'd3,
    U_VPERM = 3'd4,
    U_CR    = 3'd5,
    U_BR    = 3'd6,
    U_PSEUDO= 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    HZ_NONE  = 2'd0,
    HZ_STALL = 2'd1,
    HZ_NOOP  = 2'd2
  } hz_e;

  typedef struct packed {
    logic             close;
    logic [CNT_W-1:0] cnt;
  } adv_t;

  // Advance the slot count by add slots, optionally jumping to the last slot first.
  function automatic adv_t slot_advance(logic [CNT_W-1:0] cur, logic [1:0] add,
                                        logic to_last);
    adv_t r;
    logic [CNT_W:0] base;
    logic [CNT_W:0] sum;
    base = to_last ? (CNT_W+1)'(GROUP_SLOTS - 1) : {1'b0, cur};
    sum  = base + (CNT_W+1)'(add);
    if (sum >= (CNT_W+1)'(GROUP_SLOTS)) begin
      r.close = 1'b1;
      r.cnt   = '0;
    end else begin
      r.close = 1'b0;
      r.cnt   = sum[CNT_W-1:0];
    end
    return r;
  endfunction

  function automatic logic is_exec_unit(unit_e u);
    return (u == U_FX) || (u == U_LS) || (u == U_FP) ||
           (u == U_VALU) || (u == U_VPERM);
  endfunction

endpackage

// File: rtl/dgh_hazard_eval.sv
module dgh_hazard_eval
  import dgh_pkg::*;
(
  input  unit_e            unit,
  input  logic             first_only,
  input  logic             single,
  input  logic             cracked,
  input  logic             is_load,
  input  logic             addr_overlap,
  input  logic             ctr_branch,
  input  logic [CNT_W-1:0] slots,
  input  logic             ctr_pending,
  output hz_e              verdict,
  output logic             stall_hit,
  output logic             noop_hit
);

  logic real_instr;
  logic stall_pos;
  logic stall_crack;
  logic stall_exec;
  logic stall_cr;

  assign real_instr  = (unit != U_PSEUDO);
  assign stall_pos   = (slots != '0) && (first_only || single);
  assign stall_crack = cracked && (slots > CNT_W'(CRACK_LIMIT));
  assign stall_exec  = is_exec_unit(unit) && (slots == CNT_W'(EXEC_LIMIT));
  assign stall_cr    = (unit == U_CR) && (slots >= CNT_W'(CR_LIMIT));

  assign stall_hit = real_instr && (stall_pos || stall_crack || stall_exec || stall_cr);
  assign noop_hit  = real_instr && ((ctr_pending && ctr_branch) ||
                                    (is_load && addr_overlap));

  always_comb begin
    if (stall_hit)     verdict = HZ_STALL;
    else if (noop_hit) verdict = HZ_NOOP;
    else               verdict = HZ_NONE;
  end

endmodule

// File: rtl/dgh_slot_state.sv
module dgh_slot_state
  import dgh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_stb,
  input  logic             idle_stb,
  input  unit_e            unit,
  input  logic             single,
  input  logic             cracked,
  input  logic             writes_ctr,
  output logic [CNT_W-1:0] slots,
  output logic             ctr_pending,
  output logic             group_close
);

  logic             commit_real;
  logic             active;
  logic [1:0]       add;
  logic             to_last;
  adv_t             adv;
  logic [CNT_W-1:0] slots_q;
  logic             ctr_q;

  assign commit_real = commit_stb && (unit != U_PSEUDO);
  assign active      = commit_real || idle_stb;

  always_comb begin
    if (commit_real) begin
      add     = cracked ? 2'd2 : 2'd1;
      to_last = (unit == U_BR) || single;
    end else begin
      add     = 2'd1;
      to_last = 1'b0;
    end
  end

  assign adv         = slot_advance(slots_q, add, to_last);
  assign group_close = active && adv.close;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_q <= '0;
      ctr_q   <= 1'b0;
    end else if (active) begin
      slots_q <= adv.cnt;
      ctr_q   <= adv.close ? 1'b0 : (ctr_q || (commit_real && writes_ctr));
    end
  end

  assign slots       = slots_q;
  assign ctr_pending = ctr_q;

endmodule

// File: rtl/dgroup_hazard_chk.sv
module dgroup_hazard_chk
  import dgh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cand_unit,
  input  logic       cand_first_only,
  input  logic       cand_single,
  input  logic       cand_cracked,
  input  logic       cand_is_load,
  input  logic       cand_addr_overlap,
  input  logic       cand_writes_ctr,
  input  logic       cand_ctr_branch,
  input  logic       commit_stb,
  input  logic       idle_stb,
  output logic [1:0] hazard,
  output logic [2:0] slots_used,
  output logic       ctr_pending
);

  unit_e            unit;
  hz_e              verdict;
  logic [CNT_W-1:0] slots;
  logic             stall_hit;
  logic             noop_hit;
  logic             group_close;

  assign unit = unit_e'(cand_unit);

  dgh_slot_state state_i (
    .clk         (clk),
    .rst         (rst),
    .commit_stb  (commit_stb),
    .idle_stb    (idle_stb),
    .unit        (unit),
    .single      (cand_single),
    .cracked     (cand_cracked),
    .writes_ctr  (cand_writes_ctr),
    .slots       (slots),
    .ctr_pending (ctr_pending),
    .group_close (group_close)
  );

  dgh_hazard_eval eval_i (
    .unit         (unit),
    .first_only   (cand_first_only),
    .single       (cand_single),
    .cracked      (cand_cracked),
    .is_load      (cand_is_load),
    .addr_overlap (cand_addr_overlap),
    .ctr_branch   (cand_ctr_branch),
    .slots        (slots),
    .ctr_pending  (ctr_pending),
    .verdict      (verdict),
    .stall_hit    (stall_hit),
    .noop_hit     (noop_hit)
  );

  assign hazard     = 2'(verdict);
  assign slots_used = 3'(slots);

endmodule

// File: rtl/dgh_checker.sv
module dgh_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cand_unit,
  input logic       cand_first_only,
  input logic       cand_single,
  input logic       cand_cracked,
  input logic       cand_ctr_branch,
  input logic       commit_stb,
  input logic       idle_stb,
  input logic [1:0] hazard,
  input logic [2:0] slots_used,
  input logic       ctr_pending,
  input logic       stall_hit,
  input logic       noop_hit,
  input logic       group_close
);

  // R7
  slots_bound_chk: assert property (@(posedge clk) disable iff (rst)
    slots_used <= 3'd4);

  // R7
  close_empties_chk: assert property (@(posedge clk) disable iff (rst)
    group_close |=> (slots_used == 3'd0) && !ctr_pending);

  // R2
  pseudo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_unit == 3'd7) |-> (hazard == 2'd0));

  // R2
  pseudo_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_stb && !idle_stb && cand_unit == 3'd7) |=>
      (slots_used == $past(slots_used)) && (ctr_pending == $past(ctr_pending)));

  // R3
  first_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ((cand_first_only || cand_single) && cand_unit != 3'd7 && slots_used != 3'd0)
      |-> (hazard == 2'd1));

  // R4
  crack_room_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_cracked && cand_unit != 3'd7 && slots_used > 3'd2) |-> (hazard == 2'd1));

  // R6
  cr_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_unit == 3'd5 && slots_used >= 3'd2) |-> (hazard == 2'd1));

  // R8
  branch_close_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_stb && cand_unit == 3'd6) |=> (slots_used == 3'd0) && !ctr_pending);

  // R9
  idle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_stb && !commit_stb) |=>
      (slots_used == (($past(slots_used) == 3'd4) ? 3'd0 : $past(slots_used) + 3'd1)));

  // R10
  ctr_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctr_pending && cand_ctr_branch && cand_unit != 3'd7 && !stall_hit)
      |-> (hazard == 2'd2));

  // R12
  stall_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_hit && noop_hit) |-> (hazard == 2'd1));

endmodule

bind dgroup_hazard_chk dgh_checker chk_i (.*);

// File: tb/dgroup_hazard_chk_tb_top.sv
module dgroup_hazard_chk_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cand_unit;
  logic       cand_first_only, cand_single, cand_cracked;
  logic       cand_is_load, cand_addr_overlap, cand_writes_ctr, cand_ctr_branch;
  logic       commit_stb, idle_stb;
  logic [1:0] hazard;
  logic [2:0] slots_used;
  logic       ctr_pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [2:0] FX = 0, LS = 1, FP = 2, VA = 3, VP = 4, CR = 5, BR = 6, PS = 7;
  localparam int NONE = 0, STALL = 1, NOOP = 2;

  always #(CLK_PERIOD/2) clk = ~clk;

  dgroup_hazard_chk dut_i (
    .clk(clk), .rst(rst), .cand_unit(cand_unit),
    .cand_first_only(cand_first_only), .cand_single(cand_single),
    .cand_cracked(cand_cracked), .cand_is_load(cand_is_load),
    .cand_addr_overlap(cand_addr_overlap), .cand_writes_ctr(cand_writes_ctr),
    .cand_ctr_branch(cand_ctr_branch), .commit_stb(commit_stb), .idle_stb(idle_stb),
    .hazard(hazard), .slots_used(slots_used), .ctr_pending(ctr_pending)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cand(logic [2:0] u, bit fo = 0, bit sg = 0, bit cr = 0,
                      bit ld = 0, bit ov = 0, bit wc = 0, bit cb = 0);
    cand_unit = u; cand_first_only = fo; cand_single = sg; cand_cracked = cr;
    cand_is_load = ld; cand_addr_overlap = ov; cand_writes_ctr = wc; cand_ctr_branch = cb;
    #1;
  endtask

  task automatic pulse(bit c, bit i);
    commit_stb = c; idle_stb = i;
    @(negedge clk);
    commit_stb = 0; idle_stb = 0;
    #1;
  endtask

  task automatic close_group();
    cand(BR);
    pulse(1, 0);
  endtask

  task automatic t_reset();
    cand(FX);
    chk("R1 slots", slots_used, 0);
    chk("R1 ctr", ctr_pending, 0);
    chk("R1 verdict", hazard, NONE);
  endtask

  task automatic t_fill();
    for (int k = 1; k <= 4; k++) begin
      cand(FX); pulse(1, 0);
      chk("R7 count", slots_used, k);
    end
    cand(FX); chk("R5 fx at 4", hazard, STALL);
    cand(VP); chk("R5 vperm at 4", hazard, STALL);
    cand(BR); chk("R5 branch at 4", hazard, NONE);
    pulse(1, 0);
    chk("R7 close at five", slots_used, 0);
  endtask

  task automatic t_pseudo();
    cand(FX); pulse(1, 0);
    cand(PS, 1, 1, 1); chk("R2 pseudo verdict", hazard, NONE);
    cand(PS, 0, 0, 0, 0, 0, 1); pulse(1, 0);
    chk("R2 pseudo commit count", slots_used, 1);
    chk("R2 pseudo commit ctr", ctr_pending, 0);
    close_group();
  endtask

  task automatic t_first();
    cand(FP, 1); chk("R3 first-only empty", hazard, NONE);
    cand(FX); pulse(1, 0);
    cand(FP, 1); chk("R3 first-only at 1", hazard, STALL);
    cand(FX, 0, 1); chk("R3 single at 1", hazard, STALL);
    close_group();
    cand(FX, 0, 1); chk("R3 single empty", hazard, NONE);
    pulse(1, 0);
    chk("R8 single closes", slots_used, 0);
    cand(FX); pulse(1, 0); pulse(1, 0);
    close_group();
    chk("R8 branch closes from 2", slots_used, 0);
  endtask

  task automatic t_crack();
    cand(LS, 0, 0, 1); pulse(1, 0);
    chk("R4 cracked adds two", slots_used, 2);
    cand(LS, 0, 0, 1); chk("R4 cracked at 2", hazard, NONE);
    cand(FX); pulse(1, 0);
    cand(LS, 0, 0, 1); chk("R4 cracked at 3", hazard, STALL);
    cand(CR); chk("R6 cr at 3", hazard, STALL);
    close_group();
  endtask

  task automatic t_cr();
    cand(CR); chk("R6 cr at 0", hazard, NONE);
    cand(FX); pulse(1, 0);
    cand(CR); chk("R6 cr at 1", hazard, NONE);
    cand(FX); pulse(1, 0);
    cand(CR); chk("R6 cr at 2", hazard, STALL);
    close_group();
  endtask

  task automatic t_idle();
    cand(FX);
    for (int k = 1; k <= 5; k++) begin
      pulse(0, 1);
      chk("R9 idle step", slots_used, k % 5);
    end
    cand(FX, 0, 0, 1); pulse(1, 1);
    chk("R9 commit wins over idle", slots_used, 2);
    close_group();
  endtask

  task automatic t_ctr();
    cand(FX, 0, 0, 0, 0, 0, 1); pulse(1, 0);
    chk("R10 ctr set", ctr_pending, 1);
    cand(BR, 0, 0, 0, 0, 0, 0, 1); chk("R10 ctr branch noop", hazard, NOOP);
    cand(BR); chk("R10 plain branch", hazard, NONE);
    pulse(1, 0);
    chk("R10 ctr cleared", ctr_pending, 0);
    cand(BR, 0, 0, 0, 0, 0, 0, 1); chk("R10 ctr branch new group", hazard, NONE);
    cand(FX, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 5; k++) pulse(k == 0, k != 0);
    chk("R7 ctr cleared by idle close", ctr_pending, 0);
  endtask

  task automatic t_load();
    cand(LS, 0, 0, 0, 1, 1); chk("R11 load overlap", hazard, NOOP);
    cand(LS, 0, 0, 0, 1, 0); chk("R11 load no overlap", hazard, NONE);
    cand(FX, 0, 0, 0, 0, 1); chk("R11 overlap non-load", hazard, NONE);
  endtask

  task automatic t_prio();
    cand(FX); for (int k = 0; k < 4; k++) pulse(1, 0);
    cand(LS, 0, 0, 0, 1, 1); chk("R12 stall over noop", hazard, STALL);
    close_group();
    cand(FX, 0, 0, 0, 0, 0, 1); pulse(1, 0);
    cand(BR, 1, 0, 0, 0, 0, 0, 1); chk("R12 first-only ctr branch", hazard, STALL);
    close_group();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst = 1; commit_stb = 0; idle_stb = 0;
    cand_unit = FX; cand_first_only = 0; cand_single = 0; cand_cracked = 0;
    cand_is_load = 0; cand_addr_overlap = 0; cand_writes_ctr = 0; cand_ctr_branch = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    t_reset();
    t_fill();
    t_pseudo();
    t_first();
    t_crack();
    t_cr();
    t_idle();
    t_ctr();
    t_load();
    t_prio();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule